// File: doc/BRIEF.md
# Encryption context control unit

This block keeps the security context that a transparent memory encryption datapath needs while a protected application runs. The integer pipeline hands it one decoded control operation at a time, together with the current program counter and two 32-bit operand values. The block updates its context registers and drives the datapath. It owns the application identifier, the code and data encryption enables, the shared-memory mode flag, and the two 64-bit shared keys: one for encrypting and one for decrypting.

An application opens a context with an enter operation. Enter captures the program counter as the identifier, and this capture is the only way the identifier is written. An exit operation closes the context and wipes every register. Both of these operations also wipe the caches: the block raises the instruction- and data-cache flush requests and holds them until a flush-done acknowledge arrives. It reports the operation complete only after that acknowledge. Between enter and exit, the application can suspend and restore data encryption. It can also move data traffic onto the shared key with the identifier forced to zero, and it can load the shared keys. None of these operations touches the caches.

Top module: `enc_ctx_ctrl`

## Requirements
- R1: After reset the identifier, both keys and all enables are zero, no flush is requested and `op_ready` is high.
- R2: Enter (op code 1) loads `ctx_id` with `pc`, turns code and data encryption on, clears shared mode, and raises both flush requests in the cycle after it is accepted.
- R3: A flush request stays high until `flush_done` is sampled high. `op_done` pulses for one cycle after that sample. While the flush is pending `op_ready` is low and any operation offered is dropped. A `flush_done` with no flush pending has no effect.
- R4: Exit (op code 2) zeroes the identifier, both keys and all flags, and requests both flushes.
- R5: Pause (op code 3) turns only data encryption off. Code encryption and the identifier are kept. Resume (op code 4) turns data encryption back on. Neither operation requests a flush, and each pulses `op_done` in the cycle after acceptance.
- R6: Shared-on (op code 5) sets `data_key_shared` and forces `data_id` to zero while `ctx_id` keeps its value. Shared-off (op code 6) restores `data_id` to `ctx_id` and leaves both keys unchanged.
- R7: Set-encrypt-key (op code 7) and set-decrypt-key (op code 8) load their key as {`opnd_a`, `opnd_b`}, with `opnd_a` in bits 63:32.
- R8: With no context active (code encryption off), op codes 3 to 8 change nothing and give no `op_done`.
- R9: Op codes 0 and 9 to 15 change nothing and give no `op_done`, whether or not a context is active.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| op_valid | input | 1 | An operation is offered this cycle |
| op_code | input | 4 | Decoded operation code |
| pc | input | 32 | Program counter of the issuing instruction |
| opnd_a | input | 32 | First operand, upper key half |
| opnd_b | input | 32 | Second operand, lower key half |
| flush_done | input | 1 | Caches report the requested flush finished |
| op_ready | output | 1 | An offered operation is taken this cycle |
| op_done | output | 1 | One-cycle completion pulse |
| ctx_id | output | 32 | Application identifier (used for code) |
| data_id | output | 32 | Identifier used for data tweaks |
| code_enc_en | output | 1 | Code decryption enabled |
| data_enc_en | output | 1 | Data encryption enabled |
| data_key_shared | output | 1 | Data path uses the shared keys |
| shm_enc_key | output | 64 | Shared encryption key |
| shm_dec_key | output | 64 | Shared decryption key |
| flush_ic_req | output | 1 | Instruction-cache flush request |
| flush_dc_req | output | 1 | Data-cache flush request |

## Verification
Every one of the sixteen op codes is offered both with no context and with an active one. This separates the operations that need a context from the undefined codes and from the two operations that are always honoured. Enter is repeated with a range of program counter values, with a different acknowledge delay each time, and with an operation attempted during the flush. This shows that the identifier comes from `pc` and that nothing is accepted while the flush is pending. The keys are loaded with asymmetric operand pairs, so a swapped half or a write to the wrong key shows at the outputs. Pause, resume and the shared-mode switches are interleaved, so the flags are shown to be kept independently.

// File: rtl/enc_ctx_pkg.sv
package enc_ctx_pkg;
  typedef enum logic [3:0] {
    OP_NOP      = 4'd0,
    OP_ENTER    = 4'd1,
    OP_EXIT     = 4'd2,
    OP_PAUSE    = 4'd3,
    OP_RESUME   = 4'd4,
    OP_SHM_ON   = 4'd5,
    OP_SHM_OFF  = 4'd6,
    OP_SET_EKEY = 4'd7,
    OP_SET_DKEY = 4'd8
  } ctx_op_e;

  typedef struct packed {
    logic enter;
    logic leave;
    logic pause;
    logic resume;
    logic shm_on;
    logic shm_off;
    logic set_ekey;
    logic set_dkey;
  } ctx_cmd_t;
endpackage

// File: rtl/enc_ctx_decode.sv
module enc_ctx_decode
  import enc_ctx_pkg::*;
(
  input  logic       op_valid,
  input  logic [3:0] op_code,
  input  logic       ready,
  input  logic       active,
  output ctx_cmd_t   cmd
);
  logic accept;
  logic gated;

  assign accept = op_valid & ready;
  assign gated  = accept & active;

  always_comb begin
    cmd          = '0;
    cmd.enter    = accept & (op_code == OP_ENTER);
    cmd.leave    = accept & (op_code == OP_EXIT);
    cmd.pause    = gated  & (op_code == OP_PAUSE);
    cmd.resume   = gated  & (op_code == OP_RESUME);
    cmd.shm_on   = gated  & (op_code == OP_SHM_ON);
    cmd.shm_off  = gated  & (op_code == OP_SHM_OFF);
    cmd.set_ekey = gated  & (op_code == OP_SET_EKEY);
    cmd.set_dkey = gated  & (op_code == OP_SET_DKEY);
  end
endmodule

// File: rtl/enc_ctx_state.sv
module enc_ctx_state
  import enc_ctx_pkg::*;
#(
  parameter int ID_W = 32
) (
  input  logic            clk,
  input  logic            rst_n,
  input  ctx_cmd_t        cmd,
  input  logic [ID_W-1:0] pc,
  output logic [ID_W-1:0] id_q,
  output logic            active_q,
  output logic            data_on_q,
  output logic            shm_q
);
  logic [ID_W-1:0] id_d;
  logic            active_d, data_on_d, shm_d, upd;

  assign upd = cmd.enter | cmd.leave | cmd.pause | cmd.resume | cmd.shm_on | cmd.shm_off;

  always_comb begin
    id_d      = id_q;
    active_d  = active_q;
    data_on_d = data_on_q;
    shm_d     = shm_q;
    if (cmd.leave) begin
      id_d      = '0;
      active_d  = 1'b0;
      data_on_d = 1'b0;
      shm_d     = 1'b0;
    end else if (cmd.enter) begin
      id_d      = pc;
      active_d  = 1'b1;
      data_on_d = 1'b1;
      shm_d     = 1'b0;
    end else begin
      if (cmd.pause)   data_on_d = 1'b0;
      if (cmd.resume)  data_on_d = 1'b1;
      if (cmd.shm_on)  shm_d     = 1'b1;
      if (cmd.shm_off) shm_d     = 1'b0;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      id_q      <= '0;
      active_q  <= 1'b0;
      data_on_q <= 1'b0;
      shm_q     <= 1'b0;
    end else if (upd) begin
      id_q      <= id_d;
      active_q  <= active_d;
      data_on_q <= data_on_d;
      shm_q     <= shm_d;
    end
  end

  // R2: the identifier is written only by enter or exit
  p_id_only_enter_r2: assert property (@(posedge clk) disable iff (!rst_n)
    (!cmd.enter && !cmd.leave) |=> $stable(id_q));
  // R2: enter captures the program counter
  p_enter_loads_pc_r2: assert property (@(posedge clk) disable iff (!rst_n)
    cmd.enter |=> (id_q == $past(pc)));
  // R5: code encryption stays on until an exit
  p_code_until_exit_r5: assert property (@(posedge clk) disable iff (!rst_n)
    (active_q && !cmd.leave) |=> active_q);
endmodule

// File: rtl/enc_ctx_keys.sv
module enc_ctx_keys #(
  parameter int OPND_W = 32,
  parameter int NKEY   = 2
) (
  input  logic                          clk,
  input  logic                          rst_n,
  input  logic [NKEY-1:0]               load,
  input  logic                          clr,
  input  logic [OPND_W-1:0]             opnd_a,
  input  logic [OPND_W-1:0]             opnd_b,
  output logic [NKEY-1:0][2*OPND_W-1:0] key_q
);
  localparam int KEY_W = 2 * OPND_W;

  for (genvar g = 0; g < NKEY; g++) begin : g_key
    logic [KEY_W-1:0] key_d;
    logic             en;

    assign en = load[g] | clr;

    always_comb begin
      if (clr) key_d = '0;
      else     key_d = {opnd_a, opnd_b};
    end

    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)  key_q[g] <= '0;
      else if (en) key_q[g] <= key_d;
    end

    // R6: a key holds its value unless loaded or wiped
    p_key_hold_r6: assert property (@(posedge clk) disable iff (!rst_n)
      (!load[g] && !clr) |=> $stable(key_q[g]));
    // R7: a load places the first operand in the upper half
    p_key_order_r7: assert property (@(posedge clk) disable iff (!rst_n)
      (load[g] && !clr) |=> (key_q[g][KEY_W-1:OPND_W] == $past(opnd_a)));
  end
endmodule

// File: rtl/enc_ctx_flush.sv
module enc_ctx_flush (
  input  logic clk,
  input  logic rst_n,
  input  logic start,
  input  logic simple_done,
  input  logic flush_done,
  output logic busy_q,
  output logic op_done_q
);
  logic busy_d, done_d;

  always_comb begin
    busy_d = busy_q;
    if (start)                    busy_d = 1'b1;
    else if (busy_q & flush_done) busy_d = 1'b0;
    done_d = simple_done | (busy_q & flush_done);
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      busy_q    <= 1'b0;
      op_done_q <= 1'b0;
    end else begin
      busy_q    <= busy_d;
      op_done_q <= done_d;
    end
  end

  // R3: a pending flush is held until acknowledged
  p_flush_hold_r3: assert property (@(posedge clk) disable iff (!rst_n)
    (busy_q && !flush_done) |=> busy_q);
  // R3: acknowledge ends the flush with a done pulse
  p_done_after_ack_r3: assert property (@(posedge clk) disable iff (!rst_n)
    (busy_q && flush_done) |=> (op_done_q && !busy_q));
endmodule

// File: rtl/enc_ctx_ctrl.sv
module enc_ctx_ctrl
  import enc_ctx_pkg::*;
#(
  parameter int ID_W   = 32,
  parameter int OPND_W = 32
) (
  input  logic                clk,
  input  logic                rst_n,
  input  logic                op_valid,
  input  logic [3:0]          op_code,
  input  logic [ID_W-1:0]     pc,
  input  logic [OPND_W-1:0]   opnd_a,
  input  logic [OPND_W-1:0]   opnd_b,
  input  logic                flush_done,
  output logic                op_ready,
  output logic                op_done,
  output logic [ID_W-1:0]     ctx_id,
  output logic [ID_W-1:0]     data_id,
  output logic                code_enc_en,
  output logic                data_enc_en,
  output logic                data_key_shared,
  output logic [2*OPND_W-1:0] shm_enc_key,
  output logic [2*OPND_W-1:0] shm_dec_key,
  output logic                flush_ic_req,
  output logic                flush_dc_req
);
  localparam int KEY_W = 2 * OPND_W;

  ctx_cmd_t              cmd;
  logic [ID_W-1:0]       id_q;
  logic                  active_q, data_on_q, shm_q, busy_q;
  logic [1:0][KEY_W-1:0] keys;
  logic                  simple_done;

  enc_ctx_decode u_dec (
    .op_valid (op_valid),
    .op_code  (op_code),
    .ready    (!busy_q),
    .active   (active_q),
    .cmd      (cmd)
  );

  enc_ctx_state #(.ID_W(ID_W)) u_state (
    .clk       (clk),
    .rst_n     (rst_n),
    .cmd       (cmd),
    .pc        (pc),
    .id_q      (id_q),
    .active_q  (active_q),
    .data_on_q (data_on_q),
    .shm_q     (shm_q)
  );

  enc_ctx_keys #(.OPND_W(OPND_W), .NKEY(2)) u_keys (
    .clk    (clk),
    .rst_n  (rst_n),
    .load   ({cmd.set_dkey, cmd.set_ekey}),
    .clr    (cmd.leave),
    .opnd_a (opnd_a),
    .opnd_b (opnd_b),
    .key_q  (keys)
  );

  assign simple_done = cmd.pause | cmd.resume | cmd.shm_on | cmd.shm_off
                     | cmd.set_ekey | cmd.set_dkey;

  enc_ctx_flush u_flush (
    .clk         (clk),
    .rst_n       (rst_n),
    .start       (cmd.enter | cmd.leave),
    .simple_done (simple_done),
    .flush_done  (flush_done),
    .busy_q      (busy_q),
    .op_done_q   (op_done)
  );

  assign op_ready        = !busy_q;
  assign ctx_id          = id_q;
  assign data_id         = shm_q ? '0 : id_q;
  assign code_enc_en     = active_q;
  assign data_enc_en     = active_q & data_on_q;
  assign data_key_shared = active_q & shm_q;
  assign shm_enc_key     = keys[0];
  assign shm_dec_key     = keys[1];
  assign flush_ic_req    = busy_q;
  assign flush_dc_req    = busy_q;

  // R6: shared mode always presents a zero data identifier
  p_shm_zero_id_r6: assert property (@(posedge clk) disable iff (!rst_n)
    data_key_shared |-> (data_id == '0));
  // R8: context-bound operations give no completion while inactive
  p_ignore_inactive_r8: assert property (@(posedge clk) disable iff (!rst_n)
    (!code_enc_en && op_valid && op_ready && op_code >= 4'd3 && op_code <= 4'd8)
      |=> !op_done);
  // R9: undefined codes give no completion
  p_undef_quiet_r9: assert property (@(posedge clk) disable iff (!rst_n)
    (op_valid && op_ready && (op_code == 4'd0 || op_code >= 4'd9)) |=> !op_done);
endmodule

// File: tb/enc_ctx_ctrl_bench.sv
module enc_ctx_ctrl_bench;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        op_valid = 1'b0;
  logic [3:0]  op_code = '0;
  logic [31:0] pc = '0, opnd_a = '0, opnd_b = '0;
  logic        flush_done = 1'b0;
  logic        op_ready, op_done, code_enc_en, data_enc_en, data_key_shared;
  logic        flush_ic_req, flush_dc_req;
  logic [31:0] ctx_id, data_id;
  logic [63:0] shm_enc_key, shm_dec_key;

  int tests = 0;
  int fails = 0;

  logic [31:0] m_id;
  logic        m_act, m_don, m_shm;
  logic [63:0] m_ek, m_dk;

  always #10 clk = ~clk;

  enc_ctx_ctrl u_enc_ctx_ctrl (
    .clk(clk), .rst_n(rst_n), .op_valid(op_valid), .op_code(op_code), .pc(pc),
    .opnd_a(opnd_a), .opnd_b(opnd_b), .flush_done(flush_done),
    .op_ready(op_ready), .op_done(op_done), .ctx_id(ctx_id), .data_id(data_id),
    .code_enc_en(code_enc_en), .data_enc_en(data_enc_en),
    .data_key_shared(data_key_shared), .shm_enc_key(shm_enc_key),
    .shm_dec_key(shm_dec_key), .flush_ic_req(flush_ic_req), .flush_dc_req(flush_dc_req)
  );

  task automatic chk(input string tag, input logic [63:0] act, input logic [63:0] exp);
    tests++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s act=%h exp=%h", tag, act, exp);
    end
  endtask

  task automatic chk_ctx(input string tag);
    chk({tag, " ctx_id"},  {32'h0, ctx_id}, {32'h0, m_id});
    chk({tag, " data_id"}, {32'h0, data_id}, {32'h0, (m_shm ? 32'h0 : m_id)});
    chk({tag, " flags"}, {61'h0, code_enc_en, data_enc_en, data_key_shared},
        {61'h0, m_act, m_act & m_don, m_act & m_shm});
    chk({tag, " ekey"}, shm_enc_key, m_ek);
    chk({tag, " dkey"}, shm_dec_key, m_dk);
  endtask

  task automatic issue(input logic [3:0] c, input logic [31:0] p,
                       input logic [31:0] a, input logic [31:0] b);
    @(negedge clk);
    op_valid = 1'b1; op_code = c; pc = p; opnd_a = a; opnd_b = b;
    @(posedge clk);
    @(negedge clk);
    op_valid = 1'b0;
  endtask

  task automatic ack(input int wait_cyc);
    repeat (wait_cyc) @(negedge clk);
    flush_done = 1'b1;
    @(posedge clk);
    @(negedge clk);
    flush_done = 1'b0;
  endtask

  // Check flush requested and completion after acknowledge
  task automatic flush_seq(input string tag, input int wait_cyc);
    chk({tag, " flush req"}, {61'h0, flush_ic_req, flush_dc_req, op_ready}, 64'h6);
    chk({tag, " no early done"}, {63'h0, op_done}, 64'h0);
    ack(wait_cyc);
    chk({tag, " R3 done after ack"},
        {61'h0, op_done, flush_ic_req | flush_dc_req, op_ready}, 64'h5);
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    fails++;
    $display("FAIL watchdog act=running exp=finished");
    $display("[TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end

  initial begin
    m_id = '0; m_act = 0; m_don = 0; m_shm = 0; m_ek = '0; m_dk = '0;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    // R1: reset state
    chk_ctx("R1 reset");
    chk("R1 ready/flush", {61'h0, op_ready, flush_ic_req, flush_dc_req}, 64'h4);

    // R8, R9: every non-enter/exit code is dropped with no context
    for (int c = 0; c < 16; c++) begin
      if (c == 1 || c == 2) continue;
      issue(4'(c), 32'hDEAD_0000 + 32'(c), 32'hA5A5_0000 | 32'(c), 32'h5A5A_FFFF);
      chk_ctx((c >= 3 && c <= 8) ? "R8 inactive" : "R9 undefined");
      chk("R8 R9 no done/flush", {62'h0, op_done, flush_ic_req}, 64'h0);
    end

    // R3: spurious acknowledge with nothing pending
    ack(0);
    chk("R3 idle ack", {62'h0, op_done, op_ready}, 64'h1);

    // R2, R3: enter with varied pc and acknowledge delays
    for (int i = 0; i < 8; i++) begin
      logic [31:0] p;
      p = 32'h4000_0000 + 32'(i) * 32'h0123_4567;
      issue(4'd1, p, 32'h0, 32'h0);
      m_id = p; m_act = 1; m_don = 1; m_shm = 0;
      chk_ctx("R2 enter");
      // an operation offered during the flush is dropped
      issue(4'd3, 32'h0, 32'h0, 32'h0);
      chk_ctx("R3 drop while flushing");
      flush_seq("R2 enter", i);
    end

    // R7: key loads with asymmetric halves
    for (int k = 0; k < 4; k++) begin
      logic [31:0] a, b;
      a = 32'h1111_0000 + 32'(k) * 32'h0F0F_0101;
      b = 32'hF000_0001 ^ (32'(k) << 8);
      issue(4'd7, 32'h0, a, b);
      m_ek = {a, b};
      chk_ctx("R7 set ekey");
      chk("R7 ekey done", {63'h0, op_done}, 64'h1);
      issue(4'd8, 32'h0, b, a);
      m_dk = {b, a};
      chk_ctx("R7 set dkey");
    end

    // R5: pause and resume
    issue(4'd3, 32'h0, 32'h0, 32'h0);
    m_don = 0;
    chk_ctx("R5 pause");
    chk("R5 pause done no flush", {62'h0, op_done, flush_ic_req}, 64'h2);
    issue(4'd4, 32'h0, 32'h0, 32'h0);
    m_don = 1;
    chk_ctx("R5 resume");
    chk("R5 resume done no flush", {62'h0, op_done, flush_dc_req}, 64'h2);

    // R6: shared mode on/off interleaved with pause
    issue(4'd5, 32'h0, 32'h0, 32'h0);
    m_shm = 1;
    chk_ctx("R6 shm on");
    chk("R6 shm on no flush", {62'h0, op_done, flush_ic_req}, 64'h2);
    issue(4'd3, 32'h0, 32'h0, 32'h0);
    m_don = 0;
    chk_ctx("R5 pause in shm");
    issue(4'd4, 32'h0, 32'h0, 32'h0);
    m_don = 1;
    issue(4'd6, 32'h0, 32'h0, 32'h0);
    m_shm = 0;
    chk_ctx("R6 shm off keys kept");

    // R9: undefined codes with an active context
    for (int c = 9; c < 16; c++) begin
      issue(4'(c), 32'h0BAD_0000, 32'hFFFF_FFFF, 32'hFFFF_FFFF);
      chk_ctx("R9 active undefined");
      chk("R9 active no done", {63'h0, op_done}, 64'h0);
    end
    issue(4'd0, 32'h0, 32'hFFFF_FFFF, 32'h0);
    chk_ctx("R9 nop");

    // R4: exit wipes everything and flushes
    issue(4'd5, 32'h0, 32'h0, 32'h0);
    m_shm = 1;
    issue(4'd2, 32'h7777_7777, 32'h0, 32'h0);
    m_id = '0; m_act = 0; m_don = 0; m_shm = 0; m_ek = '0; m_dk = '0;
    chk_ctx("R4 exit");
    flush_seq("R4 exit", 3);

    // R8: key load after exit is ignored
    issue(4'd7, 32'h0, 32'h1234_5678, 32'h9ABC_DEF0);
    chk_ctx("R8 key after exit");

    $display("[TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end
endmodule